// File: doc/BRIEF.md
# PAL Progressive Frame Sync and Bar Pattern Generator

This block produces the two digital timing signals for a progressive PAL-style composite picture, counted entirely in cycles of a 24 MHz reference clock. A sync output sits low at the sync tip level and high at the black level. A video output is high for white and low for black. An external resistor network mixes the two into the analog composite level. Every frame runs through four phases in a fixed order, and the last phase wraps straight back to the first: a group of broad vertical pulses, a group of short equalizing pulses before the picture, the picture lines, and a group of short equalizing pulses after the picture.

Each pulse phase is built from half-line segments of equal length. Each picture line is exactly two half-lines long. A picture line starts with a horizontal sync and a back porch. An active region follows, in which a fixed pattern of vertical bars is drawn. By default the pattern is three equal bands: white, black, white. Any active cycles left after the last band stay black. Two single-cycle strobes mark the first cycle of a frame and the first cycle of each picture line, so a downstream pixel source can lock onto them. A synchronous active-high reset restarts the block at the first broad pulse.

All durations are parameters. With the defaults the timing is a 768-cycle half-line, 720/48 broad pulses, 48/720 equalizing pulses, a 96-cycle sync, a 192-cycle back porch, three 416-cycle bands and 304 lines.

Top module: `pal_frame_gen`

## Requirements
- R1: While reset is high, sync, video, frame_start and line_start are all low from the first clock edge onward. In the first cycle after reset is released, the block is at the first cycle of the first broad pulse: sync is low and frame_start is high.
- R2: A frame opens with NUM_BROAD broad pulses, each HALF_CYC cycles long. In each broad pulse sync is low for the first BROAD_LOW cycles and high for the rest.
- R3: The broad pulses are followed by NUM_EQ_PRE equalizing pulses, each HALF_CYC cycles long. In each one sync is low for the first SHORT_LOW cycles and high for the rest.
- R4: The pre-picture pulses are followed by NUM_LINES picture lines, each 2*HALF_CYC cycles long. In each line sync is low for the first HSYNC_CYC cycles and high for the rest of the line.
- R5: In a picture line, take the active offset a = line cycle − (HSYNC_CYC + BPORCH_CYC). For each band k (k = 0 to NUM_BANDS−1), video equals bit k of BAND_MASK when BAND_CYC*k ≤ a < BAND_CYC*(k+1). The default mask 3'b101 gives high, low, high. Video is low for every a at or beyond NUM_BANDS*BAND_CYC.
- R6: Video is low during every broad pulse, every equalizing pulse, every horizontal sync and every back porch.
- R7: The last picture line is followed by NUM_EQ_POST equalizing pulses shaped as in R3. The next cycle is the first cycle of a new frame, so the frame period is (NUM_BROAD+NUM_EQ_PRE+NUM_EQ_POST)*HALF_CYC + NUM_LINES*2*HALF_CYC cycles.
- R8: frame_start is high for exactly one cycle per frame, on the first cycle of the first broad pulse, and never at the same time as line_start.
- R9: line_start is high for exactly one cycle per picture line, on the first cycle of that line, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase clock (24 MHz in the intended use) |
| rst_i | input | 1 | Synchronous active-high reset |
| sync_o | output | 1 | Sync level: 0 = sync tip, 1 = black level |
| video_o | output | 1 | Video level: 1 = white, 0 = black |
| frame_start_o | output | 1 | One-cycle strobe at the first cycle of each frame |
| line_start_o | output | 1 | One-cycle strobe at the first cycle of each picture line |

## Verification
The assertions assume that reset is held for at least one rising clock edge before checking starts. They also assume the timing parameters are consistent: every low time is shorter than its segment, and the bars fit inside the line. The bench's reduced parameter set satisfies both. The bench drives only the reset input. It releases reset once from power-up and once in the middle of an active band, where video is high, so the restart path is exercised from a state that is not idle. The bench parameters leave four unused active cycles at the end of each line, so the trailing-black rule of R5 is exercised.

// File: rtl/pal_fg_pkg.sv
package pal_fg_pkg;

  typedef enum logic [1:0] {
    PH_BROAD   = 2'd0,
    PH_EQ_PRE  = 2'd1,
    PH_LINES   = 2'd2,
    PH_EQ_POST = 2'd3
  } pal_phase_e;

  // Sync level for a given phase and segment cycle: low for the leading part.
  function automatic logic sync_level(pal_phase_e ph, int unsigned pos,
                                      int unsigned broad_low,
                                      int unsigned short_low,
                                      int unsigned hsync);
    unique case (ph)
      PH_BROAD: sync_level = (pos >= broad_low);
      PH_LINES: sync_level = (pos >= hsync);
      default:  sync_level = (pos >= short_low);
    endcase
  endfunction

  // First line cycle of bar k.
  function automatic int unsigned band_edge(int unsigned act0,
                                            int unsigned band,
                                            int unsigned k);
    band_edge = act0 + band * k;
  endfunction

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    max_of4 = m;
  endfunction

endpackage

// File: rtl/pal_fg_seq.sv
module pal_fg_seq
  import pal_fg_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 768,
  parameter int unsigned NUM_BROAD   = 5,
  parameter int unsigned NUM_EQ_PRE  = 5,
  parameter int unsigned NUM_LINES   = 304,
  parameter int unsigned NUM_EQ_POST = 5,
  localparam int unsigned LINE_CYC   = 2 * HALF_CYC,
  localparam int unsigned POS_W      = $clog2(LINE_CYC),
  localparam int unsigned MAX_CNT    = max_of4(NUM_BROAD, NUM_EQ_PRE, NUM_LINES, NUM_EQ_POST),
  localparam int unsigned IDX_W      = $clog2(MAX_CNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  output pal_phase_e       phase_o,
  output logic [POS_W-1:0] pos_o,
  output logic [IDX_W-1:0] idx_o
);

  pal_phase_e       phase_q;
  logic [POS_W-1:0] pos_q;
  logic [IDX_W-1:0] idx_q;
  logic [POS_W-1:0] seg_last;
  logic [IDX_W-1:0] idx_last;
  pal_phase_e       phase_nxt;

  always_comb begin
    seg_last = (phase_q == PH_LINES) ? POS_W'(LINE_CYC - 1) : POS_W'(HALF_CYC - 1);
    unique case (phase_q)
      PH_BROAD:  begin idx_last = IDX_W'(NUM_BROAD - 1);   phase_nxt = PH_EQ_PRE;  end
      PH_EQ_PRE: begin idx_last = IDX_W'(NUM_EQ_PRE - 1);  phase_nxt = PH_LINES;   end
      PH_LINES:  begin idx_last = IDX_W'(NUM_LINES - 1);   phase_nxt = PH_EQ_POST; end
      default:   begin idx_last = IDX_W'(NUM_EQ_POST - 1); phase_nxt = PH_BROAD;   end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= PH_BROAD;
      pos_q   <= '0;
      idx_q   <= '0;
    end else if (pos_q == seg_last) begin
      pos_q <= '0;
      if (idx_q == idx_last) begin
        idx_q   <= '0;
        phase_q <= phase_nxt;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end else begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign pos_o   = pos_q;
  assign idx_o   = idx_q;

endmodule

// File: rtl/pal_fg_sync.sv
module pal_fg_sync
  import pal_fg_pkg::*;
#(
  parameter int unsigned POS_W     = 11,
  parameter int unsigned BROAD_LOW = 720,
  parameter int unsigned SHORT_LOW = 48,
  parameter int unsigned HSYNC_CYC = 96
) (
  input  pal_phase_e       phase_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             sync_o
);

  always_comb begin
    sync_o = sync_level(phase_i, 32'(pos_i), BROAD_LOW, SHORT_LOW, HSYNC_CYC);
  end

endmodule

// File: rtl/pal_fg_bars.sv
module pal_fg_bars
  import pal_fg_pkg::*;
#(
  parameter int unsigned              POS_W      = 11,
  parameter int unsigned              HSYNC_CYC  = 96,
  parameter int unsigned              BPORCH_CYC = 192,
  parameter int unsigned              BAND_CYC   = 416,
  parameter int unsigned              NUM_BANDS  = 3,
  parameter logic [NUM_BANDS-1:0]     BAND_MASK  = 3'b101,
  localparam int unsigned             ACT0       = HSYNC_CYC + BPORCH_CYC
) (
  input  pal_phase_e       phase_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             video_o
);

  logic [NUM_BANDS-1:0] band_hit;

  for (genvar k = 0; k < NUM_BANDS; k++) begin : g_band
    localparam int unsigned LO = band_edge(ACT0, BAND_CYC, k);
    localparam int unsigned HI = band_edge(ACT0, BAND_CYC, k + 1);
    assign band_hit[k] = (phase_i == PH_LINES) &&
                         (32'(pos_i) >= LO) && (32'(pos_i) < HI);
  end

  assign video_o = |(band_hit & BAND_MASK);

endmodule

// File: rtl/pal_frame_gen.sv
module pal_frame_gen
  import pal_fg_pkg::*;
#(
  parameter int unsigned          HALF_CYC    = 768,
  parameter int unsigned          BROAD_LOW   = 720,
  parameter int unsigned          SHORT_LOW   = 48,
  parameter int unsigned          HSYNC_CYC   = 96,
  parameter int unsigned          BPORCH_CYC  = 192,
  parameter int unsigned          BAND_CYC    = 416,
  parameter int unsigned          NUM_BANDS   = 3,
  parameter logic [NUM_BANDS-1:0] BAND_MASK   = 3'b101,
  parameter int unsigned          NUM_BROAD   = 5,
  parameter int unsigned          NUM_EQ_PRE  = 5,
  parameter int unsigned          NUM_LINES   = 304,
  parameter int unsigned          NUM_EQ_POST = 5
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic sync_o,
  output logic video_o,
  output logic frame_start_o,
  output logic line_start_o
);

  localparam int unsigned LINE_CYC = 2 * HALF_CYC;
  localparam int unsigned POS_W    = $clog2(LINE_CYC);
  localparam int unsigned MAX_CNT  = max_of4(NUM_BROAD, NUM_EQ_PRE, NUM_LINES, NUM_EQ_POST);
  localparam int unsigned IDX_W    = $clog2(MAX_CNT + 1);

  pal_phase_e       phase_w;
  logic [POS_W-1:0] pos_w;
  logic [IDX_W-1:0] idx_w;

  // Named internal events, observed by the checker.
  logic seg_start_w;
  logic in_lines_w;

  pal_fg_seq #(
    .HALF_CYC   (HALF_CYC),
    .NUM_BROAD  (NUM_BROAD),
    .NUM_EQ_PRE (NUM_EQ_PRE),
    .NUM_LINES  (NUM_LINES),
    .NUM_EQ_POST(NUM_EQ_POST)
  ) seq_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .phase_o(phase_w),
    .pos_o  (pos_w),
    .idx_o  (idx_w)
  );

  pal_fg_sync #(
    .POS_W    (POS_W),
    .BROAD_LOW(BROAD_LOW),
    .SHORT_LOW(SHORT_LOW),
    .HSYNC_CYC(HSYNC_CYC)
  ) sync_i (
    .phase_i(phase_w),
    .pos_i  (pos_w),
    .sync_o (sync_o)
  );

  pal_fg_bars #(
    .POS_W     (POS_W),
    .HSYNC_CYC (HSYNC_CYC),
    .BPORCH_CYC(BPORCH_CYC),
    .BAND_CYC  (BAND_CYC),
    .NUM_BANDS (NUM_BANDS),
    .BAND_MASK (BAND_MASK)
  ) bars_i (
    .phase_i(phase_w),
    .pos_i  (pos_w),
    .video_o(video_o)
  );

  assign seg_start_w   = (pos_w == '0);
  assign in_lines_w    = (phase_w == PH_LINES);
  assign frame_start_o = !rst_i && seg_start_w && (phase_w == PH_BROAD) && (idx_w == '0);
  assign line_start_o  = !rst_i && seg_start_w && in_lines_w;

endmodule

// File: rtl/pal_frame_gen_chk.sv
module pal_frame_gen_chk (
  input logic clk_i,
  input logic rst_i,
  input logic sync_o,
  input logic video_o,
  input logic frame_start_o,
  input logic line_start_o,
  input logic seg_start_i,
  input logic in_lines_i
);

  AST_VIDEO_BLACK_IN_SYNC: assert property (@(posedge clk_i) disable iff (rst_i)
    !sync_o |-> !video_o); // R6

  AST_VIDEO_ONLY_IN_LINES: assert property (@(posedge clk_i) disable iff (rst_i)
    video_o |-> in_lines_i); // R5

  AST_FRAME_START_SYNC_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_start_o |-> (!sync_o && !in_lines_i)); // R8

  AST_FRAME_START_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_start_o |=> !frame_start_o); // R8

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
    !(frame_start_o && line_start_o)); // R8

  AST_LINE_START_AT_LINE: assert property (@(posedge clk_i) disable iff (rst_i)
    line_start_o |-> (in_lines_i && !sync_o)); // R9

  AST_SYNC_FALLS_AT_SEGMENT: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(sync_o) |-> seg_start_i); // R4

endmodule

bind pal_frame_gen pal_frame_gen_chk chk_i (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .sync_o       (sync_o),
  .video_o      (video_o),
  .frame_start_o(frame_start_o),
  .line_start_o (line_start_o),
  .seg_start_i  (seg_start_w),
  .in_lines_i   (in_lines_w)
);

// File: tb/pal_frame_gen_tb.sv
module pal_frame_gen_tb_top;

  localparam int HALF  = 32;
  localparam int BLOW  = 28;
  localparam int SLOW  = 4;
  localparam int HS    = 4;
  localparam int BP    = 8;
  localparam int BAND  = 16;
  localparam int NB    = 5;
  localparam int NE1   = 5;
  localparam int NL    = 6;
  localparam int NE2   = 5;
  localparam int LINE  = 2 * HALF;
  localparam int FRAME = (NB + NE1 + NE2) * HALF + NL * LINE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_o, video_o, fs_o, ls_o;
  int   errors = 0;
  int   checks = 0;
  bit   done   = 1'b0;

  always #2.5 clk = ~clk;

  pal_frame_gen #(
    .HALF_CYC(HALF), .BROAD_LOW(BLOW), .SHORT_LOW(SLOW), .HSYNC_CYC(HS),
    .BPORCH_CYC(BP), .BAND_CYC(BAND), .NUM_BANDS(3), .BAND_MASK(3'b101),
    .NUM_BROAD(NB), .NUM_EQ_PRE(NE1), .NUM_LINES(NL), .NUM_EQ_POST(NE2)
  ) dut_i (
    .clk_i(clk), .rst_i(rst), .sync_o(sync_o), .video_o(video_o),
    .frame_start_o(fs_o), .line_start_o(ls_o)
  );

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // Behavioural reference: everything follows from the cycle number since reset.
  task automatic compare(int t);
    int    f, r;
    logic  e_sync, e_vid, e_fs, e_ls;
    string rs, rv;
    f = t % FRAME;
    e_vid = 1'b0;
    e_ls  = 1'b0;
    rv    = "R6";
    e_fs  = (f == 0);
    if (f < NB * HALF) begin
      e_sync = (f % HALF) >= BLOW;
      rs = "R2";
    end else if (f < (NB + NE1) * HALF) begin
      e_sync = (f % HALF) >= SLOW;
      rs = "R3";
    end else if (f < (NB + NE1) * HALF + NL * LINE) begin
      int q, a;
      q = (f - (NB + NE1) * HALF) % LINE;
      a = q - HS - BP;
      e_sync = q >= HS;
      e_ls   = (q == 0);
      rs = "R4";
      if (a >= 0) begin
        rv = "R5";
        if (a < BAND)           e_vid = 1'b1;
        else if (a < 3 * BAND && a >= 2 * BAND) e_vid = 1'b1;
      end
    end else begin
      e_sync = (f % HALF) >= SLOW;
      rs = "R7";
    end
    r = t;
    if (r == 0) begin
      rs = "R1";
    end
    check(rs, "sync", sync_o, e_sync);
    check(rv, "video", video_o, e_vid);
    check((r == 0) ? "R1" : "R8", "frame_start", fs_o, e_fs);
    check("R9", "line_start", ls_o, e_ls);
  endtask

  task automatic run_from_release(int ncyc);
    @(negedge clk);
    rst = 1'b0;
    #1 compare(0);
    for (int t = 1; t < ncyc; t++) begin
      @(negedge clk);
      compare(t);
    end
  endtask

  initial begin : main
    int mid;
    // Reset held from time zero: check after the first edge.
    repeat (4) begin
      @(negedge clk);
      check("R1", "sync in reset", sync_o, 1'b0);
      check("R1", "video in reset", video_o, 1'b0);
      check("R1", "frame_start in reset", fs_o, 1'b0);
      check("R1", "line_start in reset", ls_o, 1'b0);
    end
    // Two full frames and a bit; stop in an active band (video high) of frame 3.
    mid = 2 * FRAME + (NB + NE1) * HALF + 2 * LINE + HS + BP + 3;
    run_from_release(mid);
    @(negedge clk);
    check("R5", "video before mid reset", video_o, 1'b1);
    rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R1", "sync in mid reset", sync_o, 1'b0);
      check("R1", "video in mid reset", video_o, 1'b0);
      check("R1", "frame_start in mid reset", fs_o, 1'b0);
      check("R1", "line_start in mid reset", ls_o, 1'b0);
    end
    run_from_release(FRAME + 10);
    done = 1'b1;
  end

  initial begin : watchdog
    int n;
    n = 0;
    while (!done && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule